// File: doc/BRIEF.md
# Pseudo-Random Auto Trigger Generator

This block produces a free-running stream of single-cycle trigger pulses for self-triggered acquisition. The spacing between consecutive pulses is a fixed part set by an unsigned base value plus a pseudo-random part. The random part's range is set by an exponent. With the exponent at zero the spacing is strictly periodic. Larger exponents add random jitter that spans up to a power of two cycles.

The generator has no enable of its own. It starts running when reset is released and never stops. Any consumer that does not want the pulses simply does not select them. Besides the pulse, the block reports how many pulses it has issued since reset.

The random term comes from a 32-bit maximal-length shift register. The register moves one step for each pulse. The base and exponent are sampled in the pulse cycle, so each interval is fixed at the moment it begins.

Top module: `auto_trigger_gen`

## Requirements
- R1: While `rst_n` is low, `trig_pulse` is 0 and `pulse_count` is 0. The first pulse is high during the cycle that follows the first rising clock edge seen with `rst_n` high.
- R2: The number of clock cycles from the start of one pulse to the start of the next is T = 1 + M + R. M is `base_gap`, taken as an unsigned number. R is the random term defined in R3.
- R3: R = (S AND (2^N − 1)) + 1. S is the random state, and N is `rand_exp`, taken as an unsigned number. R therefore lies between 1 and 2^N. After reset, S is 32'h1D87_2B41. One step replaces S with (S >> 1) XOR (32'h8020_0003 if S[0] is 1, otherwise 0). R is computed from S as it stands before that pulse's step.
- R4: S takes exactly one step per pulse and holds its value in every other cycle.
- R5: Each pulse is high for exactly one clock cycle, and two pulses are never adjacent.
- R6: M and N are sampled only in the pulse cycle. Changing them during an interval has no effect on that interval. The new values set the length of the interval that starts at the next pulse.
- R7: `pulse_count` increases by one on the clock edge that ends each pulse, and holds at all other edges. During the k-th pulse after reset it reads k−1.
- R8: With N = 0 the spacing is exactly M + 2. With M = 0 and N = 0, a pulse occurs every second cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_gap | input | GAP_W (32) | Fixed part M of the spacing |
| rand_exp | input | EXP_W (5) | Exponent N setting the random range |
| trig_pulse | output | 1 | Single-cycle trigger pulse |
| pulse_count | output | PCNT_W (32) | Number of pulses issued since reset |

## Verification
Two properties are hard to expose from the ports. One is that M and N are sampled only at the start of an interval. The other is that the random state steps only on pulses, since a state that stepped every cycle would still give plausible spacings. To reach both, the bench holds its own copy of the random state and predicts each spacing from the values on the inputs during the pulse cycle. It also rewrites M and N a few cycles into a long interval and checks that the interval in progress keeps its old length. A long-spacing phase makes a state that stepped per cycle diverge quickly from the prediction. A reset in the middle of a run checks that the sequence starts again from the seed.

// File: rtl/atg_pkg.sv
package atg_pkg;
  // Galois right-shift taps for x^32 + x^22 + x^2 + x + 1
  localparam logic [31:0] ATG_TAPS32 = 32'h8020_0003;
  localparam logic [31:0] ATG_SEED32 = 32'h1D87_2B41;

  // width of the countdown that holds M + R without overflow
  function automatic int span_width(input int gap_w);
    return gap_w + 2;
  endfunction
endpackage

// File: rtl/atg_lfsr.sv
module atg_lfsr #(
  parameter int             W    = 32,
  parameter logic [W-1:0]   TAPS = atg_pkg::ATG_TAPS32,
  parameter logic [W-1:0]   SEED = atg_pkg::ATG_SEED32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  output logic [W-1:0] state
);
  function automatic logic [W-1:0] galois_step(input logic [W-1:0] s);
    return (s >> 1) ^ ({W{s[0]}} & TAPS);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   state <= SEED;
    else if (adv) state <= galois_step(state);
  end

  assert_state_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    state != '0);
  assert_hold_without_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(state));
  assert_moves_on_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> state != $past(state));
endmodule

// File: rtl/atg_interval.sv
module atg_interval #(
  parameter int GAP_W  = 32,
  parameter int EXP_W  = 5,
  parameter int RND_W  = 32,
  localparam int CNT_W = atg_pkg::span_width(GAP_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [GAP_W-1:0] base_gap,
  input  logic [EXP_W-1:0] rand_exp,
  input  logic [RND_W-1:0] rnd,
  output logic             expire,
  output logic [CNT_W-1:0] remain
);
  logic run_q;
  logic [CNT_W-1:0] load_val;

  // random term: low N bits of the state plus one, range 1 .. 2^N
  function automatic logic [CNT_W-1:0] rand_term(input logic [RND_W-1:0] s,
                                                 input logic [EXP_W-1:0] n);
    logic [CNT_W-1:0] msk;
    msk = (CNT_W'(1) << n) - CNT_W'(1);
    return (CNT_W'(s) & msk) + CNT_W'(1);
  endfunction

  // countdown reload: spacing minus one, i.e. M + R
  function automatic logic [CNT_W-1:0] reload(input logic [GAP_W-1:0] m,
                                              input logic [RND_W-1:0] s,
                                              input logic [EXP_W-1:0] n);
    return CNT_W'(m) + rand_term(s, n);
  endfunction

  assign load_val = reload(base_gap, rnd, rand_exp);
  assign expire   = run_q && (remain == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      remain <= '0;
    end else begin
      run_q <= 1'b1;
      if (expire)     remain <= load_val;
      else if (run_q) remain <= remain - CNT_W'(1);
    end
  end

  assert_single_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> !expire);
  assert_load_above_base_R2: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> remain > {2'b00, $past(base_gap)});
  assert_load_within_span_R3: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> remain <= {2'b00, $past(base_gap)} + (CNT_W'(1) << $past(rand_exp)));
  assert_countdown_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !expire) |=> remain == $past(remain) - CNT_W'(1));
endmodule

// File: rtl/atg_pulse_count.sv
module atg_pulse_count #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   count <= '0;
    else if (inc) count <= count + W'(1);
  end

  assert_count_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    inc |=> count == $past(count) + W'(1));
  assert_count_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !inc |=> $stable(count));
endmodule

// File: rtl/auto_trigger_gen.sv
module auto_trigger_gen #(
  parameter int                GAP_W     = 32,
  parameter int                EXP_W     = 5,
  parameter int                LFSR_W    = 32,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = atg_pkg::ATG_TAPS32,
  parameter logic [LFSR_W-1:0] LFSR_SEED = atg_pkg::ATG_SEED32,
  parameter int                PCNT_W    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [GAP_W-1:0]  base_gap,
  input  logic [EXP_W-1:0]  rand_exp,
  output logic              trig_pulse,
  output logic [PCNT_W-1:0] pulse_count
);
  localparam int CNT_W = atg_pkg::span_width(GAP_W);

  // named internal events for checking
  logic              ev_expire;
  logic [LFSR_W-1:0] rnd_state;
  logic [CNT_W-1:0]  cycles_left;

  atg_lfsr #(.W(LFSR_W), .TAPS(LFSR_TAPS), .SEED(LFSR_SEED)) u_lfsr (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (ev_expire),
    .state (rnd_state)
  );

  atg_interval #(.GAP_W(GAP_W), .EXP_W(EXP_W), .RND_W(LFSR_W)) u_interval (
    .clk      (clk),
    .rst_n    (rst_n),
    .base_gap (base_gap),
    .rand_exp (rand_exp),
    .rnd      (rnd_state),
    .expire   (ev_expire),
    .remain   (cycles_left)
  );

  atg_pulse_count #(.W(PCNT_W)) u_count (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (ev_expire),
    .count (pulse_count)
  );

  assign trig_pulse = ev_expire;

  assert_pulse_on_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    trig_pulse |-> cycles_left == '0);
  assert_no_adjacent_R5: assert property (@(posedge clk) disable iff (!rst_n)
    trig_pulse |=> !trig_pulse);
endmodule

// File: tb/test_auto_trigger_gen.sv
`timescale 1ns/1ps
module test_auto_trigger_gen;
  localparam logic [31:0] SEED = 32'h1D87_2B41;
  localparam logic [31:0] TAPS = 32'h8020_0003;
  localparam int NV = 6;
  // stimulus vectors: base M, exponent N, pulses to observe
  localparam int VEC_M [NV] = '{3, 0, 0, 17, 60, 5};
  localparam int VEC_N [NV] = '{2, 0, 4, 0, 6, 3};
  localparam int VEC_K [NV] = '{6, 8, 6, 5, 5, 6};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] base_gap = 32'd3;
  logic [4:0]  rand_exp = 5'd2;
  logic        trig_pulse;
  logic [31:0] pulse_count;

  int    n_tests = 0;
  int    n_fail  = 0;
  int    cyc     = 0;
  string cur_tag = "R2";

  // model state
  logic [31:0] ms;
  longint      exp_gap;
  longint      gap;
  bit          have_exp;
  bit          prev_trig;
  int          seen;

  auto_trigger_gen i_auto_trigger_gen (
    .clk(clk), .rst_n(rst_n), .base_gap(base_gap), .rand_exp(rand_exp),
    .trig_pulse(trig_pulse), .pulse_count(pulse_count)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  function automatic logic [31:0] model_step(input logic [31:0] s);
    logic [31:0] t;
    t = {1'b0, s[31:1]};
    if (s[0]) t = t ^ TAPS;
    return t;
  endfunction

  // continuous monitor: spacing, single-cycle width, pulse count
  always @(negedge clk) begin
    if (!rst_n) begin
      ms = SEED; have_exp = 0; seen = 0; prev_trig = 0; gap = 0;
    end else begin
      gap++;
      if (trig_pulse) begin
        if (prev_trig) chk(1'b0, "R5", "adjacent pulse", 1, 0);
        if (have_exp) chk(gap == exp_gap, cur_tag, "spacing R2", gap, exp_gap);
        chk(pulse_count == 32'(seen), "R7", "count in pulse", pulse_count, seen);
        exp_gap = 1 + longint'(base_gap)
                + longint'(ms & ((32'd1 << rand_exp) - 32'd1)) + 1;
        ms = model_step(ms);
        have_exp = 1; gap = 0; seen++;
      end else if (have_exp && gap >= exp_gap) begin
        chk(1'b0, cur_tag, "late pulse R2", gap, exp_gap);
        have_exp = 0;
      end
      prev_trig = trig_pulse;
    end
  end

  task automatic wait_pulses(input int k);
    int c = 0;
    while (c < k) begin
      @(negedge clk);
      if (trig_pulse) c++;
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_fail++;
      $display("FAIL R2 watchdog: actual %0d cycles expected below %0d", cyc, 100000);
      summary();
      $finish;
    end
  end

  initial begin
    // R1: quiet while in reset
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(trig_pulse == 1'b0, "R1", "pulse in reset", trig_pulse, 0);
      chk(pulse_count == 0, "R1", "count in reset", pulse_count, 0);
    end
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    chk(trig_pulse == 1'b0, "R1", "before first edge", trig_pulse, 0);
    @(negedge clk);
    chk(trig_pulse == 1'b1, "R1", "first pulse", trig_pulse, 1);

    // table walk: spacing and random term
    for (int i = 0; i < NV; i++) begin
      @(posedge clk); #1;
      base_gap = 32'(VEC_M[i]);
      rand_exp = 5'(VEC_N[i]);
      cur_tag  = (VEC_N[i] == 0) ? "R8" : "R3";
      wait_pulses(VEC_K[i]);
    end

    // R5: the cycle after a pulse is low
    base_gap = 32'd2; rand_exp = 5'd1;
    wait_pulses(1);
    @(negedge clk);
    chk(trig_pulse == 1'b0, "R5", "width", trig_pulse, 0);

    // R4: long spacings expose a state that steps every cycle
    @(posedge clk); #1 base_gap = 32'd50; rand_exp = 5'd5; cur_tag = "R4";
    wait_pulses(5);

    // R6: change inputs inside a long interval
    @(posedge clk); #1 base_gap = 32'd40; rand_exp = 5'd1; cur_tag = "R3";
    wait_pulses(2);
    repeat (5) @(posedge clk);
    #1 base_gap = 32'd4; rand_exp = 5'd3; cur_tag = "R6";
    wait_pulses(4);

    // R1/R3: reset mid-run restarts count and sequence
    @(posedge clk); #1 rst_n = 1'b0;
    @(negedge clk);
    chk(pulse_count == 0, "R1", "count after reset", pulse_count, 0);
    chk(trig_pulse == 1'b0, "R1", "pulse after reset", trig_pulse, 0);
    @(posedge clk); #1 rst_n = 1'b1; base_gap = 32'd7; rand_exp = 5'd4; cur_tag = "R3";
    wait_pulses(6);

    summary();
    $finish;
  end
endmodule